// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Core

This core keeps time of day and the calendar in packed BCD registers. A once-per-second enable, produced elsewhere from a 32.768 kHz reference, advances the seconds. A carry passes through minutes, hours, day of week, date, month and year, all in the same clock cycle. The hours register holds its own format selector, so software picks a 24-hour or a 12-hour AM/PM count by the value it writes. Months end on their true last day, and February has a 29th in leap years. A stop bit in a control register freezes the count while writes still land.

A host reaches the core through a small internal bus: a write strobe with address and data, and a separate read address that returns the byte combinationally. The register indices are fixed: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control. Any read index above 7 returns 0.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers hold seconds 00, minutes 00, hours 00 (24-hour), day of week 1, date 01, month 01, year 00, and control 00 (counting runs).
- R2: A write stores the data ANDed with a per-register mask, and reads return the stored value. The masks are 0x7F for seconds, minutes and hours, 0x07 for day of week, 0x3F for date, 0x1F for month, 0xFF for year and 0x80 for control. Unimplemented bits therefore always read 0.
- R3: On an effective tick, seconds count 00 to 59 in BCD. On wrapping to 00 they carry into minutes, which count 00 to 59 and carry into hours the same way.
- R4: With hours bit 6 = 0 (24-hour mode), bits 5:0 count BCD 00 to 23. A carry from 23 gives 00 and advances the day.
- R5: With hours bit 6 = 1 (12-hour mode), bits 4:0 hold the BCD hour and bit 5 = 1 means PM. The hour sequence is 12, 01, ..., 11. The step from 11 to 12 toggles bit 5, and the day advances only when that step goes from PM to AM.
- R6: A day advance steps day of week 1 to 7 and wraps from 7 to 1.
- R7: A day advance steps the date. After the month's last day (31, 30, or 28 for February) the date becomes 01 and the month advances. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: When the BCD year is divisible by 4 (00 counts), February's last day is 29.
- R9: While control bit 7 is 1, ticks have no effect on any register. Writes are still applied.
- R10: A write in the same cycle as a tick takes priority for the written register. The other registers advance as computed from the values held before the write.
- R11: A single tick ripples a full carry from seconds through year within one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write register index |
| wrData | input | 8 | Write data |
| rdAddr | input | ADDR_W | Read register index |
| rdData | output | 8 | Read data for rdAddr (combinational) |

## Verification
The hardest states to reach from the ports are the rare rollovers: 11 PM to 12 AM, 31 December of year 99, and the end of February in leap and non-leap years. Free running would take days or years of simulated ticks to reach them. The stimulus loads each register to one tick before the boundary through the write port, then issues a single tick. A random phase adds legal writes, some of them colliding with ticks, and toggles of the stop bit, all against a bench calendar model.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NUM_TIME = 7;
  localparam int CTRL_IDX = 7;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  // index 0 is the rightmost element
  localparam logic [NUM_TIME-1:0][7:0] REG_MASK =
    {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h7F, 8'h7F, 8'h7F};
  localparam logic [NUM_TIME-1:0][7:0] REG_RST =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  typedef struct packed {
    logic                tickEn;
    logic [NUM_TIME-1:0] wrSel;
  } strobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    if (yr[4]) isLeap = (yr[1:0] == 2'd2);
    else       isLeap = (yr[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      8'h02:                      lastDay = isLeap(yr) ? 8'h29 : 8'h28;
      default:                    lastDay = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              ctrlBit,
  output strobe_t           strb,
  output logic              oscHalt
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(CTRL_IDX));

  always_ff @(posedge clk) begin
    if (!rstN)       oscHalt <= 1'b0;
    else if (ctrlWr) oscHalt <= ctrlBit;
  end

  assign strb.tickEn = secTick && !oscHalt;

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_sel
    assign strb.wrSel[g] = wrEn && (wrAddr == ADDR_W'(g));
  end

  // R9: the stop bit follows the last control write
  a_r9_halt_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (oscHalt == $past(ctrlBit)));
endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              oscHalt,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  logic [NUM_TIME-1:0][7:0] timeReg;
  logic [NUM_TIME-1:0][7:0] nextVal;
  logic secCarry, minCarry, hourCarry, dateCarry, monCarry;
  logic [7:0] monthEnd;

  assign secCarry  = strb.tickEn && (timeReg[IDX_SEC] == 8'h59);
  assign minCarry  = secCarry && (timeReg[IDX_MIN] == 8'h59);
  assign monthEnd  = lastDay(timeReg[IDX_MON], timeReg[IDX_YEAR]);
  assign dateCarry = hourCarry && (timeReg[IDX_DATE] == monthEnd);
  assign monCarry  = dateCarry && (timeReg[IDX_MON] == 8'h12);

  always_comb begin
    logic [7:0] hr;
    logic [7:0] tmp;
    nextVal   = timeReg;
    hourCarry = 1'b0;
    hr  = timeReg[IDX_HOUR];
    tmp = 8'h00;
    if (strb.tickEn) nextVal[IDX_SEC] = secCarry ? 8'h00 : bcdInc(timeReg[IDX_SEC]);
    if (secCarry)    nextVal[IDX_MIN] = minCarry ? 8'h00 : bcdInc(timeReg[IDX_MIN]);
    if (minCarry) begin
      if (!hr[6]) begin
        if (hr[5:0] == 6'h23) begin
          nextVal[IDX_HOUR][5:0] = 6'h00;
          hourCarry = 1'b1;
        end else begin
          tmp = bcdInc({2'b00, hr[5:0]});
          nextVal[IDX_HOUR][5:0] = tmp[5:0];
        end
      end else begin
        if (hr[4:0] == 5'h12) begin
          nextVal[IDX_HOUR][4:0] = 5'h01;
        end else if (hr[4:0] == 5'h11) begin
          nextVal[IDX_HOUR][4:0] = 5'h12;
          nextVal[IDX_HOUR][5]   = !hr[5];
          hourCarry = hr[5];
        end else begin
          tmp = bcdInc({3'b000, hr[4:0]});
          nextVal[IDX_HOUR][4:0] = tmp[4:0];
        end
      end
    end
    if (hourCarry) begin
      nextVal[IDX_DOW]  = (timeReg[IDX_DOW] == 8'h07) ? 8'h01 : timeReg[IDX_DOW] + 8'h01;
      nextVal[IDX_DATE] = dateCarry ? 8'h01 : bcdInc(timeReg[IDX_DATE]);
    end
    if (dateCarry) nextVal[IDX_MON]  = monCarry ? 8'h01 : bcdInc(timeReg[IDX_MON]);
    if (monCarry)  nextVal[IDX_YEAR] = (timeReg[IDX_YEAR] == 8'h99) ? 8'h00
                                                                    : bcdInc(timeReg[IDX_YEAR]);
  end

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)              timeReg[g] <= REG_RST[g];
      else if (strb.wrSel[g]) timeReg[g] <= wrData & REG_MASK[g];
      else                    timeReg[g] <= nextVal[g];
    end
  end

  always_comb begin
    if (rdAddr < ADDR_W'(NUM_TIME))       rdData = timeReg[rdAddr[2:0]];
    else if (rdAddr == ADDR_W'(CTRL_IDX)) rdData = {oscHalt, 7'b0};
    else                                  rdData = 8'h00;
  end

  // R3: seconds wrap from 59 to 00
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tickEn && timeReg[IDX_SEC] == 8'h59 && !strb.wrSel[IDX_SEC])
      |=> (timeReg[IDX_SEC] == 8'h00));
  // R5: 11 -> 12 in 12-hour mode flips AM/PM
  a_r5_pm_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (minCarry && timeReg[IDX_HOUR][6] && timeReg[IDX_HOUR][4:0] == 5'h11
      && !strb.wrSel[IDX_HOUR])
      |=> (timeReg[IDX_HOUR][4:0] == 5'h12
           && timeReg[IDX_HOUR][5] != $past(timeReg[IDX_HOUR][5])));
  // R7: the date returns to 01 after the month's last day
  a_r7_date_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (hourCarry && timeReg[IDX_DATE] == monthEnd && !strb.wrSel[IDX_DATE])
      |=> (timeReg[IDX_DATE] == 8'h01));
  // R9: without a tick or write, time holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tickEn && strb.wrSel == '0) |=> $stable(timeReg));
  // R10: a write wins over a simultaneous tick
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tickEn && strb.wrSel[IDX_SEC]) |=> (timeReg[IDX_SEC] == {1'b0, $past(wrData[6:0])}));
  // R2: unimplemented seconds bit reads zero
  a_r2_sec_msb_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(IDX_SEC)) |-> (rdData[7] == 1'b0));
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  strobe_t strb;
  logic    oscHalt;

  rtc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .ctrlBit(wrData[7]), .strb(strb), .oscHalt(oscHalt));

  rtc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .oscHalt(oscHalt),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData));
endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
  logic clk = 0, rstN = 0, secTick = 0, wrEn = 0;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  int nChk = 0, nErr = 0;
  bit done = 0;
  logic [7:0] m [8];

  rtc_calendar_core dut (.clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData));

  always #5 clk = ~clk;

  function automatic logic [7:0] maskOf(int a);
    case (a)
      0, 1, 2: maskOf = 8'h7F;
      3: maskOf = 8'h07;
      4: maskOf = 8'h3F;
      5: maskOf = 8'h1F;
      6: maskOf = 8'hFF;
      default: maskOf = 8'h80;
    endcase
  endfunction

  function automatic logic [7:0] toBcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int fromBcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int monLen(logic [7:0] mon, logic [7:0] yr);
    int mo = fromBcd(mon);
    if (mo == 2) return (fromBcd(yr) % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // bench model of one clock edge, from the requirements
  task automatic modelEdge(bit tick, bit we, int wa, logic [7:0] wd);
    logic [7:0] n [8];
    bit dayAdv = 0;
    int s, mi, h, dt;
    foreach (m[i]) n[i] = m[i];
    if (tick && !m[7][7]) begin
      s = fromBcd(m[0]) + 1;
      n[0] = toBcd(s % 60);
      if (s == 60) begin
        mi = fromBcd(m[1]) + 1;
        n[1] = toBcd(mi % 60);
        if (mi == 60) begin
          if (!m[2][6]) begin
            h = fromBcd({2'b0, m[2][5:0]}) + 1;
            if (h == 24) begin h = 0; dayAdv = 1; end
            n[2] = toBcd(h);
          end else begin
            h = fromBcd({3'b0, m[2][4:0]});
            n[2] = m[2];
            if (h == 12) n[2][4:0] = 5'h01;
            else if (h == 11) begin
              n[2][4:0] = 5'h12; n[2][5] = ~m[2][5]; dayAdv = m[2][5];
            end else begin
              n[2][4:0] = 5'(toBcd(h + 1));
            end
          end
        end
      end
      if (dayAdv) begin
        n[3] = (m[3] == 7) ? 8'd1 : m[3] + 8'd1;
        dt = fromBcd(m[4]);
        if (dt == monLen(m[5], m[6])) begin
          n[4] = 8'h01;
          if (m[5] == 8'h12) begin
            n[5] = 8'h01;
            n[6] = toBcd((fromBcd(m[6]) + 1) % 100);
          end else n[5] = toBcd(fromBcd(m[5]) + 1);
        end else n[4] = toBcd(dt + 1);
      end
    end
    if (we) n[wa] = wd & maskOf(wa);
    foreach (m[i]) m[i] = n[i];
  endtask

  task automatic cyc(bit tick, bit we, int wa, logic [7:0] wd);
    @(negedge clk);
    secTick = tick; wrEn = we; wrAddr = 3'(wa); wrData = wd;
    @(posedge clk);
    modelEdge(tick, we, wa, wd);
    #1;
    secTick = 0; wrEn = 0;
  endtask

  task automatic setReg(int a, logic [7:0] d); cyc(0, 1, a, d); endtask

  task automatic checkAll(string tag);
    for (int a = 0; a < 8; a++) begin
      rdAddr = 3'(a);
      #1;
      nChk++;
      if (rdData !== m[a]) begin
        nErr++;
        $display("FAIL %s reg %0d: actual %h expected %h", tag, a, rdData, m[a]);
      end
    end
  endtask

  task automatic loadTime(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                          logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    setReg(0, s); setReg(1, mi); setReg(2, h); setReg(3, dw);
    setReg(4, dt); setReg(5, mo); setReg(6, yr);
  endtask

  function automatic logic [7:0] legalVal(int a);
    case (a)
      0, 1: return toBcd($urandom_range(59));
      2: if ($urandom_range(1)) return 8'h40 | (8'($urandom_range(1)) << 5) | toBcd($urandom_range(12, 1));
         else return toBcd($urandom_range(23));
      3: return 8'($urandom_range(7, 1));
      4: return toBcd($urandom_range(28, 1));
      5: return toBcd($urandom_range(12, 1));
      6: return toBcd($urandom_range(99));
      default: return ($urandom_range(3) == 0) ? 8'h80 : 8'h00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1305));
    m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 1; m[4] = 1; m[5] = 1; m[6] = 0; m[7] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    checkAll("R1 reset");

    for (int a = 0; a < 8; a++) setReg(a, 8'hFF);
    checkAll("R2 masks");
    setReg(7, 8'h00);

    loadTime(8'h58, 8'h10, 8'h05, 8'h02, 8'h10, 8'h06, 8'h21);
    cyc(1, 0, 0, 0); checkAll("R3 sec step");
    cyc(1, 0, 0, 0); checkAll("R3 min carry");

    loadTime(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    cyc(1, 0, 0, 0); checkAll("R4/R6/R7/R11 full ripple");

    loadTime(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h03, 8'h22);
    cyc(1, 0, 0, 0); checkAll("R5 11PM to 12AM");
    loadTime(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h03, 8'h22);
    cyc(1, 0, 0, 0); checkAll("R5 11AM to 12PM");
    loadTime(8'h59, 8'h59, 8'h52, 8'h03, 8'h15, 8'h03, 8'h22);
    cyc(1, 0, 0, 0); checkAll("R5 12AM to 1AM");

    loadTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    cyc(1, 0, 0, 0); checkAll("R7 Feb non-leap");
    loadTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    cyc(1, 0, 0, 0); checkAll("R8 Feb 29");
    setReg(0, 8'h59); setReg(1, 8'h59); setReg(2, 8'h23);
    cyc(1, 0, 0, 0); checkAll("R8 Feb 29 to Mar");
    loadTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    cyc(1, 0, 0, 0); checkAll("R8 year 10 not leap");
    loadTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    cyc(1, 0, 0, 0); checkAll("R8 year 00 leap");
    loadTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h05);
    cyc(1, 0, 0, 0); checkAll("R7 30-day month");

    setReg(0, 8'h59); setReg(7, 8'h80);
    repeat (3) cyc(1, 0, 0, 0);
    checkAll("R9 halted ticks");
    setReg(1, 8'h42); checkAll("R9 write while halted");
    setReg(7, 8'h00);

    setReg(0, 8'h59); setReg(1, 8'h05);
    cyc(1, 1, 0, 8'h30); checkAll("R10 write beats tick");

    setReg(4, 8'h01);
    for (int i = 0; i < 3000; i++) begin
      int a = $urandom_range(7);
      bit tk = ($urandom_range(3) != 0);
      bit we = ($urandom_range(9) == 0);
      cyc(tk, we, a, legalVal(a));
      if (i % 50 == 0) checkAll("R3/R9/R10 random");
    end
    checkAll("R11 random end");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule